// File: doc/BRIEF.md
# Bit-Slip Word Boundary Aligner

This block recovers the word boundary of a 1-to-N serial-to-parallel converter. The boundary is arbitrary after power-up or after the clock-recovery logic is reset. The project pairs a behavioural deserializer, which accepts a bit-slip command, with an aligner that checks each assembled word against a known training word. While the boundary is wrong, the aligner sends single-cycle slip pulses. Each pulse makes the deserializer skip one incoming bit, which moves the boundary by one position modulo N. After each slip the aligner ignores a fixed number of words so that the shifted data can settle, and then it compares again.

The aligner declares lock only after the training word has been seen in several consecutive words. Once locked, it stops slipping and ignores the data until a realign request or a reset arrives. The search is bounded. If every boundary has been tried without a lock, a fail flag rises and the search starts over. The slip count is therefore found from the data and is never assumed, because the boundary can land differently on every reset.

Top module: `bsa_top`

## Requirements
- R1: The deserializer assembles FACTOR consecutive bits into a word, with the first-received bit in bit FACTOR-1 (the MSB). It pulses `word_vld_o` for one cycle every FACTOR bit cycles while no slip is applied.
- R2: A slip pulse makes the deserializer withhold exactly one incoming bit. The next word strobe comes one cycle later and the boundary rotates by one bit. No strobe occurs in the cycle after a slip.
- R3: While searching, a word that differs from `train_i` causes one slip pulse. `slip_o` is never high for two cycles in a row.
- R4: After each slip, the next SETTLE_WORDS words (default 3) are not compared. With no match, consecutive slips are spaced (SETTLE_WORDS+1)*FACTOR+1 cycles apart (33 at the defaults).
- R5: `locked_o` rises only after LOCK_RUN (default 4) consecutive compared words equal `train_i`. A run of three matches followed by a mismatch never locks.
- R6: If a mismatch calls for a slip when FACTOR slips have already been made in the current search, `fail_o` rises in the same cycle as that slip. The search then continues. `fail_o` stays high until lock, a realign request or a reset.
- R7: While locked, `slip_o` stays low and `locked_o` stays high, whatever data arrives.
- R8: A one-cycle `realign_i` clears `locked_o` and `fail_o` in the next cycle and restarts the search from a zero slip count.
- R9: For a training stream that begins k bits after reset release, the number of slips made before lock equals k mod FACTOR. After lock, `word_o` equals `train_i`.
- R10: During reset, `locked_o`, `slip_o`, `fail_o` and `word_vld_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock, one serial bit per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_i | input | 1 | Serial data bit |
| train_i | input | FACTOR | Training word to search for |
| realign_i | input | 1 | One-cycle request to restart the search |
| word_o | output | FACTOR | Deserialized word, MSB first-received |
| word_vld_o | output | 1 | One-cycle strobe marking a new word |
| slip_o | output | 1 | Bit-slip pulse issued to the deserializer |
| locked_o | output | 1 | Word boundary found |
| fail_o | output | 1 | All boundaries tried without lock |

## Verification
Training streams are delayed by several offsets, including one larger than the word width. The slip count at lock therefore shows whether the boundary was found by rotation modulo N or by luck. A stream with no training word separates the slip spacing, the fail point and the continued search from the lock path. A stream with three training words then a bad word checks that the run length, and not a single match, decides lock. Misaligning the stream after lock, and then requesting realignment, checks that the locked state ignores the data and that the search restarts with the correct extra slip count.

// File: rtl/bsa_pkg.sv
package bsa_pkg;
  // Aligner search states
  typedef enum logic [1:0] {
    AL_HUNT = 2'd0,  // compare each word against the training word
    AL_WAIT = 2'd1,  // discard words while a slip settles
    AL_LOCK = 2'd2   // boundary found, data ignored
  } al_state_e;
endpackage

// File: rtl/bsa_deser.sv
module bsa_deser #(
  parameter int FACTOR = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_i,
  input  logic              slip_i,
  output logic [FACTOR-1:0] word_o,
  output logic              vld_o
);
  localparam int CW = (FACTOR > 1) ? $clog2(FACTOR) : 1;
  localparam logic [CW-1:0] LAST = CW'(FACTOR - 1);

  logic [FACTOR-1:0] sh_q, sh_d;
  logic [FACTOR-1:0] word_q, word_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic              vld_q, vld_d;
  logic [FACTOR:0]   joined;
  logic [FACTOR-1:0] assembled;

  assign joined    = {sh_q, ser_i};
  assign assembled = joined[FACTOR-1:0];

  // Next state: a slip withholds the current bit from word assembly
  always_comb begin
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    word_d = word_q;
    vld_d  = 1'b0;
    if (!slip_i) begin
      sh_d = assembled;
      if (cnt_q == LAST) begin
        cnt_d  = '0;
        word_d = assembled;
        vld_d  = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      word_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      word_q <= word_d;
      vld_q  <= vld_d;
    end
  end

  assign word_o = word_q;
  assign vld_o  = vld_q;

  generate
    if (FACTOR > 1) begin : g_multi
      AST_VLD_PULSE: assert property (@(posedge clk) disable iff (!rst_n) vld_o |=> !vld_o); // R1
    end
  endgenerate

  AST_SLIP_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n) slip_i |=> !vld_o); // R2

endmodule

// File: rtl/bsa_aligner.sv
module bsa_aligner
  import bsa_pkg::*;
#(
  parameter int FACTOR       = 8,
  parameter int SETTLE_WORDS = 3,
  parameter int LOCK_RUN     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FACTOR-1:0] word_i,
  input  logic              vld_i,
  input  logic [FACTOR-1:0] train_i,
  input  logic              realign_i,
  output logic              slip_o,
  output logic              locked_o,
  output logic              fail_o
);
  localparam int SW = $clog2(SETTLE_WORDS + 1);
  localparam int RW = $clog2(LOCK_RUN + 1);
  localparam int NW = $clog2(FACTOR + 1);
  localparam logic [SW-1:0] SETTLE_LD = SW'(SETTLE_WORDS);
  localparam logic [RW-1:0] RUN_LAST  = RW'(LOCK_RUN - 1);
  localparam logic [NW-1:0] SLIP_MAX  = NW'(FACTOR);

  al_state_e     st_q, st_d;
  logic [SW-1:0] settle_q, settle_d;
  logic [RW-1:0] run_q, run_d;
  logic [NW-1:0] nslip_q, nslip_d;
  logic          slip_q, slip_d;
  logic          fail_q, fail_d;
  logic          hit;

  assign hit = (word_i == train_i);

  always_comb begin
    st_d     = st_q;
    settle_d = settle_q;
    run_d    = run_q;
    nslip_d  = nslip_q;
    fail_d   = fail_q;
    slip_d   = 1'b0;
    if (realign_i) begin
      st_d     = AL_HUNT;
      settle_d = '0;
      run_d    = '0;
      nslip_d  = '0;
      fail_d   = 1'b0;
    end else begin
      case (st_q)
        AL_HUNT: begin
          if (vld_i) begin
            if (hit) begin
              if (run_q == RUN_LAST) begin
                st_d    = AL_LOCK;
                run_d   = '0;
                nslip_d = '0;
                fail_d  = 1'b0;
              end else begin
                run_d = run_q + 1'b1;
              end
            end else begin
              run_d    = '0;
              slip_d   = 1'b1;
              st_d     = AL_WAIT;
              settle_d = SETTLE_LD;
              if (nslip_q == SLIP_MAX) begin
                fail_d  = 1'b1;
                nslip_d = NW'(1);
              end else begin
                nslip_d = nslip_q + 1'b1;
              end
            end
          end
        end
        AL_WAIT: begin
          if (vld_i) begin
            if (settle_q <= SW'(1)) begin
              st_d = AL_HUNT;
            end else begin
              settle_d = settle_q - 1'b1;
            end
          end
        end
        AL_LOCK: begin
          st_d = AL_LOCK;
        end
        default: st_d = AL_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= AL_HUNT;
      settle_q <= '0;
      run_q    <= '0;
      nslip_q  <= '0;
      slip_q   <= 1'b0;
      fail_q   <= 1'b0;
    end else begin
      st_q     <= st_d;
      settle_q <= settle_d;
      run_q    <= run_d;
      nslip_q  <= nslip_d;
      slip_q   <= slip_d;
      fail_q   <= fail_d;
    end
  end

  assign slip_o   = slip_q;
  assign locked_o = (st_q == AL_LOCK);
  assign fail_o   = fail_q;

  AST_SLIP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) slip_o |=> !slip_o); // R3
  AST_LOCK_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n) $rose(locked_o) |-> $past(vld_i && (word_i == train_i))); // R5
  AST_FAIL_WITH_SLIP: assert property (@(posedge clk) disable iff (!rst_n) $rose(fail_o) |-> slip_o); // R6
  AST_QUIET_LOCKED: assert property (@(posedge clk) disable iff (!rst_n) $past(locked_o) |-> !slip_o); // R7
  AST_REALIGN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) realign_i |=> (!locked_o && !fail_o)); // R8

endmodule

// File: rtl/bsa_top.sv
module bsa_top #(
  parameter int FACTOR       = 8,
  parameter int SETTLE_WORDS = 3,
  parameter int LOCK_RUN     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_i,
  input  logic [FACTOR-1:0] train_i,
  input  logic              realign_i,
  output logic [FACTOR-1:0] word_o,
  output logic              word_vld_o,
  output logic              slip_o,
  output logic              locked_o,
  output logic              fail_o
);
  logic [FACTOR-1:0] word_w;
  logic              vld_w;
  logic              slip_w;

  bsa_deser #(.FACTOR(FACTOR)) deser_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .ser_i  (ser_i),
    .slip_i (slip_w),
    .word_o (word_w),
    .vld_o  (vld_w)
  );

  bsa_aligner #(
    .FACTOR       (FACTOR),
    .SETTLE_WORDS (SETTLE_WORDS),
    .LOCK_RUN     (LOCK_RUN)
  ) align_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .word_i    (word_w),
    .vld_i     (vld_w),
    .train_i   (train_i),
    .realign_i (realign_i),
    .slip_o    (slip_w),
    .locked_o  (locked_o),
    .fail_o    (fail_o)
  );

  assign word_o     = word_w;
  assign word_vld_o = vld_w;
  assign slip_o     = slip_w;

  AST_NO_SLIP_AT_STROBE: assert property (@(posedge clk) disable iff (!rst_n) slip_o |=> !word_vld_o); // R2

endmodule

// File: tb/bsa_top_tb_top.sv
`timescale 1ns/1ps
module bsa_top_tb_top;
  localparam int N = 8;
  localparam int SETTLE = 3;
  localparam logic [N-1:0] TRAIN = 8'hB4;
  // stimulus {offset k, expected slips}
  localparam logic [7:0] VEC [5] = '{8'h00, 8'h11, 8'h44, 8'h77, 8'hA2};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_in;
  logic realign = 1'b0;
  logic [N-1:0] word_o;
  logic word_vld, slip, locked, fail;

  int total = 0;
  int bad = 0;
  int mode = 0;
  int koff = 0;
  int pos = 0;
  int cyc = 0;
  int slips_seen = 0;
  int prev_slip = 0;
  int last_gap = 0;
  int ever_locked = 0;

  always #2.5 clk = ~clk;

  bsa_top #(.FACTOR(N), .SETTLE_WORDS(SETTLE), .LOCK_RUN(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .ser_i(ser_in), .train_i(TRAIN),
    .realign_i(realign), .word_o(word_o), .word_vld_o(word_vld),
    .slip_o(slip), .locked_o(locked), .fail_o(fail)
  );

  function automatic logic stream_bit(input int p_abs);
    int p;
    logic [N-1:0] w;
    p = p_abs - koff;
    if (mode == 1 || p < 0) return 1'b0;
    w = TRAIN;
    if (mode == 2 && ((p / N) % 4) == 3) w = '0;
    return w[N-1-(p % N)];
  endfunction

  initial begin
    ser_in = 1'b0;
    forever begin
      @(negedge clk);
      if (!rst_n) pos = 0;
      else begin
        ser_in = stream_bit(pos);
        pos++;
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (locked) ever_locked = 1;
      if (slip) begin
        slips_seen++;
        last_gap = cyc - prev_slip;
        prev_slip = cyc;
      end
    end
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic do_reset(input int m, input int k);
    rst_n = 1'b0;
    mode = m;
    koff = k;
    step(3);
    @(posedge clk); #1;
    slips_seen = 0;
    ever_locked = 0;
    rst_n = 1'b1;
  endtask

  task automatic wait_lock(input int maxc);
    for (int i = 0; i < maxc && !locked; i++) step(1);
  endtask

  task automatic wait_word();
    for (int i = 0; i < 4 * N && !word_vld; i++) step(1);
  endtask

  task automatic pulse_realign();
    @(negedge clk); #1;
    realign = 1'b1;
    @(negedge clk); #1;
    realign = 1'b0;
  endtask

  initial begin
    #(150000 * 5);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R10: reset state
    step(2);
    check(!locked && !slip && !fail && !word_vld, "R10", {locked, slip, fail, word_vld}, 0);

    // R9: table of offsets and expected slip counts
    for (int v = 0; v < 5; v++) begin
      int k;
      int e;
      k = int'(VEC[v][7:4]);
      e = int'(VEC[v][3:0]);
      do_reset(0, k);
      wait_lock(2000);
      check(locked, "R9 lock", locked, 1);
      check(slips_seen == e, "R9 slips", slips_seen, e);
      wait_word();
      check(word_o == TRAIN, "R9 word", word_o, TRAIN);
    end

    // R1: strobe spacing and word content once aligned
    begin
      int c0;
      step(1);
      wait_word();
      c0 = cyc;
      step(1);
      wait_word();
      check(cyc - c0 == N, "R1 spacing", cyc - c0, N);
      check(word_o == TRAIN, "R1 msb first", word_o, TRAIN);
    end

    // R7: misalign while locked, no slips, lock held
    do_reset(0, 2);
    wait_lock(2000);
    check(slips_seen == 2, "R9 slips k2", slips_seen, 2);
    koff = 5;
    slips_seen = 0;
    step(300);
    check(slips_seen == 0, "R7 no slip", slips_seen, 0);
    check(locked, "R7 held", locked, 1);
    wait_word();
    check(word_o != TRAIN, "R7 data ignored", word_o, 0);

    // R8: realign restarts search, extra slips (5-2) mod 8
    pulse_realign();
    check(!locked && !fail, "R8 clear", locked, 0);
    slips_seen = 0;
    wait_lock(2000);
    check(locked, "R8 relock", locked, 1);
    check(slips_seen == 3, "R8 slips", slips_seen, 3);

    // R6/R4: no training word at all
    do_reset(1, 0);
    for (int i = 0; i < 3000 && !fail; i++) step(1);
    check(fail, "R6 fail rises", fail, 1);
    check(slips_seen == N + 1, "R6 slip count", slips_seen, N + 1);
    check(last_gap == (SETTLE + 1) * N + 1, "R4 gap", last_gap, (SETTLE + 1) * N + 1);
    begin
      int s0;
      s0 = slips_seen;
      step(200);
      check(slips_seen > s0, "R6 continues", slips_seen, s0 + 1);
      check(fail, "R6 sticky", fail, 1);
    end
    pulse_realign();
    check(!fail, "R8 fail cleared", fail, 0);

    // R5: three matches then a bad word never locks
    do_reset(2, 0);
    step(2500);
    check(ever_locked == 0, "R5 no lock", ever_locked, 0);
    check(fail, "R6 fail on short runs", fail, 1);

    // R3: mismatch after reset produces slips that are single pulses
    do_reset(0, 1);
    begin
      int hi2;
      hi2 = 0;
      for (int i = 0; i < 60; i++) begin
        logic prev;
        prev = slip;
        step(1);
        if (prev && slip) hi2 = 1;
      end
      check(hi2 == 0, "R3 single pulse", hi2, 0);
      check(slips_seen >= 1, "R3 slip issued", slips_seen, 1);
    end

    // R2: each slip adds one cycle to word spacing
    begin
      int c0;
      do_reset(1, 0);
      for (int i = 0; i < 200 && !slip; i++) step(1);
      c0 = cyc;
      step(1);
      wait_word();
      check(cyc - c0 == N, "R2 delayed strobe", cyc - c0, N);
    end

    // R10: reset asserted while locked
    do_reset(0, 0);
    wait_lock(2000);
    rst_n = 1'b0;
    step(1);
    check(!locked && !slip && !fail && !word_vld, "R10 mid reset", {locked, slip, fail, word_vld}, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule